// File: doc/BRIEF.md
# Dual ADC Output Port Formatter

This block sits between a pair of sample converters and the parallel output pins of a receive path. Each capture instant delivers one 12-bit sample for channel A and one for channel B, marked by a valid strobe. The block places those samples on two output buses. In dual-port operation each channel has its own bus. In multiplexed operation both channels take turns on bus A, A first and then B from the same capture. A channel-identification pin tells the receiver which channel bus A is carrying.

Static controls set the format. Samples can pass as offset binary or be turned into two's complement by flipping the top bit. The B port can be forced to zero. A single control requests that both buses and the identification pin go to high impedance; the block reports this through an output-enable line. The data-format controls are taken only when a new pair arrives. Because of this, a word on the bus never mixes settings or data from two different pairs. In multiplexed mode the valid strobe arrives at most every other clock, so the output clock runs at twice the per-channel rate.

Top module: `adc_port_fmt`

## Requirements
- R1: With mux mode off, the clock edge that accepts a pair (in_vld high) puts sample A on bus_a and sample B on bus_b; both are visible one cycle after the strobe.
- R2: With mux mode on, bus_a shows sample A in the cycle after the strobe. It shows sample B of the same pair in the cycle after that, unless a new strobe arrives. bus_b is all zeros.
- R3: In mux mode sync_o is 1 while A is on bus_a and 0 while B is on bus_a; cfg_sync_inv set reverses both levels. In dual-port mode sync_o is 0.
- R4: With cfg_twos set, every data word leaves with bit 11 inverted and bits 10..0 unchanged. With cfg_twos clear, data leaves unchanged.
- R5: In dual-port mode with cfg_two_ch low, bus_b carries all zeros.
- R6: out_en is 0 in the cycle after cfg_tristate is sampled high, and 1 in the cycle after it is sampled low.
- R7: cfg_mux, cfg_sync_inv, cfg_twos and cfg_two_ch are sampled only on the edge that accepts a pair. A change between strobes does not alter the pending B word of a mux pair or any held output.
- R8: After reset, bus_a, bus_b, sync_o and out_en are all 0. With no strobe and no pending B word, all data outputs and sync_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | New A/B sample pair present |
| in_a | input | 12 | Channel A sample, offset binary |
| in_b | input | 12 | Channel B sample, offset binary |
| cfg_mux | input | 1 | 1: both channels alternate on bus A |
| cfg_sync_inv | input | 1 | Reverse the sync pin polarity |
| cfg_twos | input | 1 | Emit two's complement (MSB inverted) |
| cfg_two_ch | input | 1 | 0: force the B port to zero |
| cfg_tristate | input | 1 | Request high impedance on buses and sync |
| bus_a | output | 12 | Output bus A |
| bus_b | output | 12 | Output bus B |
| sync_o | output | 1 | Channel identification pin |
| out_en | output | 1 | Output-enable for both buses and sync pin |

## Verification
The hardest situation to reach is a change of controls in the gap between the A word and the B word of a multiplexed pair. A correct design must still emit B with the settings of its own pair. The bench steps through all 32 combinations of the five controls with ramps on both channels. It then runs a phase in which it changes mux mode, polarity and format on the cycle right after each strobe. A behavioural model checks every output on every clock. The same run also covers back-to-back strobes in dual-port mode and long idle stretches, where the outputs must hold.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef struct packed {
        logic mux;
        logic sync_inv;
        logic twos;
        logic two_ch;
    } fmt_cfg_t;

    typedef enum logic {
        SLOT_A = 1'b0,
        SLOT_B = 1'b1
    } slot_e;

    localparam fmt_cfg_t CFG_RESET = '{mux: 1'b0, sync_inv: 1'b0, twos: 1'b0, two_ch: 1'b1};

endpackage

// File: rtl/fmt_conv.sv
module fmt_conv #(
    parameter int DW = 12
) (
    input  logic          twos,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    localparam int MSB = DW - 1;

    always_comb begin
        dout      = din;
        dout[MSB] = din[MSB] ^ twos;
    end
endmodule

// File: rtl/fmt_cfg_latch.sv
module fmt_cfg_latch
    import adc_fmt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  fmt_cfg_t cfg_in,
    output fmt_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/fmt_pair_ctrl.sv
module fmt_pair_ctrl
    import adc_fmt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_vld,
    input  logic mux_new,
    input  logic mux_act,
    output logic emit_b
);
    slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_B;
        end else if (in_vld) begin
            slot_q <= mux_new ? SLOT_A : SLOT_B;
        end else begin
            slot_q <= SLOT_B;
        end
    end

    assign emit_b = !in_vld && mux_act && (slot_q == SLOT_A);
endmodule

// File: rtl/fmt_out_stage.sv
module fmt_out_stage
    import adc_fmt_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic          emit_b,
    input  fmt_cfg_t      cfg_use,
    input  logic          tri_req,
    input  logic [DW-1:0] raw_b,
    input  logic [DW-1:0] word_a,
    input  logic [DW-1:0] word_b,
    input  logic [DW-1:0] word_hb,
    output logic [DW-1:0] hold_b,
    output logic [DW-1:0] bus_a,
    output logic [DW-1:0] bus_b,
    output logic          sync_o,
    output logic          out_en
);
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_b <= '0;
            bus_a  <= '0;
            bus_b  <= '0;
            sync_o <= 1'b0;
            out_en <= 1'b0;
        end else begin
            out_en <= !tri_req;
            if (in_vld) begin
                hold_b <= raw_b;
                bus_a  <= word_a;
                bus_b  <= (cfg_use.mux || !cfg_use.two_ch) ? '0 : word_b;
                sync_o <= cfg_use.mux ? !cfg_use.sync_inv : 1'b0;
            end else if (emit_b) begin
                bus_a  <= word_hb;
                sync_o <= cfg_use.sync_inv;
            end
        end
    end
endmodule

// File: rtl/adc_port_fmt.sv
module adc_port_fmt
    import adc_fmt_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic          cfg_mux,
    input  logic          cfg_sync_inv,
    input  logic          cfg_twos,
    input  logic          cfg_two_ch,
    input  logic          cfg_tristate,
    output logic [DW-1:0] bus_a,
    output logic [DW-1:0] bus_b,
    output logic          sync_o,
    output logic          out_en
);
    localparam int NCH = 2;

    fmt_cfg_t      cfg_new;
    fmt_cfg_t      cfg_act;
    fmt_cfg_t      cfg_use;
    logic          emit_b;
    logic [DW-1:0] hold_b;
    logic [DW-1:0] raw_w  [NCH];
    logic [DW-1:0] conv_w [NCH];
    logic [DW-1:0] conv_hb;

    assign cfg_new = '{mux: cfg_mux, sync_inv: cfg_sync_inv, twos: cfg_twos, two_ch: cfg_two_ch};
    assign cfg_use = in_vld ? cfg_new : cfg_act;
    assign raw_w[0] = in_a;
    assign raw_w[1] = in_b;

    fmt_cfg_latch u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (in_vld),
        .cfg_in (cfg_new),
        .cfg_q  (cfg_act)
    );

    fmt_pair_ctrl u_pair (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .mux_new (cfg_mux),
        .mux_act (cfg_act.mux),
        .emit_b  (emit_b)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_conv
        fmt_conv #(.DW(DW)) u_conv (
            .twos (cfg_use.twos),
            .din  (raw_w[ch]),
            .dout (conv_w[ch])
        );
    end

    fmt_conv #(.DW(DW)) u_conv_hb (
        .twos (cfg_use.twos),
        .din  (hold_b),
        .dout (conv_hb)
    );

    fmt_out_stage #(.DW(DW)) u_out (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .emit_b  (emit_b),
        .cfg_use (cfg_use),
        .tri_req (cfg_tristate),
        .raw_b   (in_b),
        .word_a  (conv_w[0]),
        .word_b  (conv_w[1]),
        .word_hb (conv_hb),
        .hold_b  (hold_b),
        .bus_a   (bus_a),
        .bus_b   (bus_b),
        .sync_o  (sync_o),
        .out_en  (out_en)
    );
endmodule

// File: rtl/fmt_chk.sv
module fmt_chk #(
    parameter int DW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic          cfg_mux,
    input logic          cfg_sync_inv,
    input logic          cfg_two_ch,
    input logic          cfg_tristate,
    input logic [DW-1:0] bus_a,
    input logic [DW-1:0] bus_b,
    input logic          sync_o,
    input logic          out_en
);
    // R2
    mux_busb_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && cfg_mux) |=> (bus_b == '0));

    // R3
    mux_sync_a_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && cfg_mux) |=> (sync_o == !$past(cfg_sync_inv)));

    // R5
    busb_forced_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !cfg_mux && !cfg_two_ch) |=> (bus_b == '0));

    // R3
    dual_sync_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !cfg_mux) |=> !sync_o);

    // R6
    tristate_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_tristate |=> !out_en);

    // R6
    tristate_on_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_tristate |=> out_en);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_vld && !$past(in_vld)) |=> ($stable(bus_a) && $stable(bus_b) && $stable(sync_o)));
endmodule

bind adc_port_fmt fmt_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_vld       (in_vld),
    .cfg_mux      (cfg_mux),
    .cfg_sync_inv (cfg_sync_inv),
    .cfg_two_ch   (cfg_two_ch),
    .cfg_tristate (cfg_tristate),
    .bus_a        (bus_a),
    .bus_b        (bus_b),
    .sync_o       (sync_o),
    .out_en       (out_en)
);

// File: tb/adc_port_fmt_tb.sv
module adc_port_fmt_tb;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_vld = 1'b0;
    logic [DW-1:0] in_a = '0;
    logic [DW-1:0] in_b = '0;
    logic          cfg_mux = 1'b0;
    logic          cfg_sync_inv = 1'b0;
    logic          cfg_twos = 1'b0;
    logic          cfg_two_ch = 1'b1;
    logic          cfg_tristate = 1'b0;
    logic [DW-1:0] bus_a;
    logic [DW-1:0] bus_b;
    logic          sync_o;
    logic          out_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    adc_port_fmt #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
        .cfg_mux(cfg_mux), .cfg_sync_inv(cfg_sync_inv), .cfg_twos(cfg_twos),
        .cfg_two_ch(cfg_two_ch), .cfg_tristate(cfg_tristate),
        .bus_a(bus_a), .bus_b(bus_b), .sync_o(sync_o), .out_en(out_en)
    );

    // behavioural reference model
    logic [DW-1:0] e_a, e_b, m_hb;
    logic          e_s, e_oe;
    bit            m_mux, m_inv, m_twos, m_pendb, m_live;

    function automatic logic [DW-1:0] conv(input logic [DW-1:0] v, input bit tw);
        logic [DW-1:0] r = v;
        if (tw) r[DW-1] = ~r[DW-1];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            e_a = '0; e_b = '0; e_s = 0; e_oe = 0;
            m_mux = 0; m_inv = 0; m_twos = 0; m_pendb = 0; m_hb = '0;
            m_live = 1;
        end else begin
            e_oe = !cfg_tristate;
            if (in_vld) begin
                m_mux = cfg_mux; m_inv = cfg_sync_inv; m_twos = cfg_twos;
                m_hb  = in_b;
                e_a   = conv(in_a, cfg_twos);
                e_b   = (cfg_mux || !cfg_two_ch) ? '0 : conv(in_b, cfg_twos);
                e_s   = cfg_mux ? !cfg_sync_inv : 1'b0;
                m_pendb = cfg_mux;
            end else if (m_pendb) begin
                e_a = conv(m_hb, m_twos);
                e_s = m_inv;
                m_pendb = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (m_live && !done) begin
            chk("R1 R2 R4 R7 R8 bus_a", bus_a, e_a);
            chk("R1 R2 R5 R7 bus_b", bus_b, e_b);
            chk("R3 R7 sync_o", {11'b0, sync_o}, {11'b0, e_s});
            chk("R6 out_en", {11'b0, out_en}, {11'b0, e_oe});
        end
    end

    logic [DW-1:0] ra = 12'h7F8;
    logic [DW-1:0] rb = 12'h005;

    task automatic pair(input bit gap);
        @(negedge clk);
        in_vld = 1; in_a = ra; in_b = rb;
        ra = ra + 12'd7; rb = rb - 12'd13;
        if (gap) begin
            @(negedge clk);
            in_vld = 0; in_a = ~in_a; in_b = ~in_b;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset bus_a", bus_a, '0);
        chk("R8 reset bus_b", bus_b, '0);
        chk("R8 reset sync_o/out_en", {10'b0, sync_o, out_en}, '0);
        rst = 0;
        // every control combination with ramps
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            in_vld = 0;
            {cfg_mux, cfg_sync_inv, cfg_twos, cfg_two_ch, cfg_tristate} = 5'(c);
            for (int p = 0; p < 6; p++) pair(1);
            idle(2);
        end
        // dual-port back-to-back pairs (R1)
        cfg_mux = 0; cfg_two_ch = 1; cfg_twos = 1; cfg_tristate = 0;
        for (int p = 0; p < 10; p++) pair(0);
        idle(3);
        // R7: controls change between A and B of a mux pair
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            in_vld = 1; in_a = ra; in_b = rb;
            cfg_mux = 1; cfg_sync_inv = k[0]; cfg_twos = k[1]; cfg_two_ch = k[2];
            ra = ra + 12'd129; rb = rb + 12'd301;
            @(negedge clk);
            in_vld = 0;
            cfg_mux = k[3]; cfg_sync_inv = !k[0]; cfg_twos = !k[1]; cfg_two_ch = !k[2];
            @(negedge clk);
            cfg_mux = !k[3];
        end
        // long idle hold (R8)
        idle(20);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule